// File: doc/BRIEF.md
# Stabilization-Gated System Clock Selector

This block decides which oscillator drives the system clock during an operating-mode change. A controller pulses `start_i` with two 4-bit selection codes:

- `cur_code_i` is the selection that belongs to the mode being left.
- `tgt_code_i` is the selection that belongs to the mode being entered.

When the two codes match, nothing has to move and the request completes at once.

When they differ and the target is a clock source, the new code is not driven onto `sel_o` until the readiness flag of that particular source is high. Until then the previous source stays selected and `stable_o` is low.

The all-ones code turns the system clock off. It is honoured only while `test_mode_i` is high. Outside test mode it is refused, and so is any code that names no source. In both refusal cases `err_o` is raised and the selection is left alone.

`done_o` marks the end of every request with a single-cycle pulse. Generating the clocks and the glitch-free multiplexing of them happen elsewhere; this block only produces the select code.

Top module: `sysclk_sel_ctrl`

## Requirements
- R1: After reset, `sel_o` is 4'h0 (internal RC source), `stable_o` is 1, and `done_o` and `err_o` are 0.
- R2: A start with `cur_code_i` equal to `tgt_code_i` changes nothing and pulses `done_o` in the next cycle with `err_o` low, whatever the code.
- R3: Target code 4'h0 (internal RC) reaches `sel_o` only at a clock edge where `rc_ready_i` is high.
- R4: Target code 4'h2 (crystal) reaches `sel_o` only at a clock edge where `xtal_ready_i` is high.
- R5: Target code 4'h4 (PLL) reaches `sel_o` only at a clock edge where `pll_ready_i` is high. While the selector waits, `sel_o` keeps its previous value and `stable_o` is 0.
- R6: Target code 4'hF with `test_mode_i` high is placed on `sel_o` in the next cycle, with `done_o` high. It does not wait for any readiness flag.
- R7: Target code 4'hF with `test_mode_i` low is refused. `sel_o` is unchanged, and `done_o` and `err_o` pulse together in the next cycle.
- R8: A target code other than 4'h0, 4'h2, 4'h4 or 4'hF, when it differs from the current code, is refused in the same way as R7.
- R9: `sel_o` changes only in a cycle where `done_o` is high. `done_o` lasts one cycle and is high only while `stable_o` is high. `err_o` is high only together with `done_o`.
- R10: A start that arrives while a switch is pending is ignored. The pending target, and only that target's readiness flag, decides the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled when idle |
| cur_code_i | input | 4 | Selection code of the mode being left |
| tgt_code_i | input | 4 | Selection code of the mode being entered |
| test_mode_i | input | 1 | Permits the clock-off code |
| rc_ready_i | input | 1 | Internal RC oscillator has settled |
| xtal_ready_i | input | 1 | Crystal oscillator has settled |
| pll_ready_i | input | 1 | PLL has locked |
| sel_o | output | 4 | Effective system clock select code |
| done_o | output | 1 | One-cycle request completion pulse |
| err_o | output | 1 | One-cycle refusal pulse, with done |
| stable_o | output | 1 | High when no switch is pending |

## Verification
The bench holds the readiness flag of the requested source low for a random number of cycles while the other flags toggle at random. A selector that looked at the wrong flag, or that did not wait at all, would move `sel_o` too early.

It also issues the clock-off code with and without test mode. A design that missed the test-mode gate would switch the clock off in normal operation, and one that over-applied it would refuse the code in test mode.

Codes that name no source, and matching current and target codes, must both leave the selection untouched. The difference is that only the first raises `err_o`.

Finally, a second request is injected while a switch is pending. A design that re-latched the target there would finish on the wrong source.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_RC   = 0;
  localparam int SRC_XTAL = 1;
  localparam int SRC_PLL  = 2;

  typedef enum logic [1:0] {
    REQ_SAME = 2'd0,
    REQ_SRC  = 2'd1,
    REQ_OFF  = 2'd2,
    REQ_BAD  = 2'd3
  } req_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } sel_state_e;
endpackage

// File: rtl/sysclk_rst_sync.sv
module sysclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sysclk_req_decode.sv
module sysclk_req_decode
  import sysclk_pkg::*;
#(
  parameter int                        CODE_W    = 4,
  parameter logic [NUM_SRC*CODE_W-1:0] SRC_CODES = {4'h4, 4'h2, 4'h0},
  parameter logic [CODE_W-1:0]         OFF_CODE  = 4'hF
) (
  input  logic [CODE_W-1:0]  cur_code,
  input  logic [CODE_W-1:0]  tgt_code,
  input  logic               test_mode,
  output req_kind_e          kind,
  output logic [NUM_SRC-1:0] src_hit
);
  // One comparator per source code
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign src_hit[g] = (tgt_code == SRC_CODES[g*CODE_W +: CODE_W]);
  end

  always_comb begin
    if (cur_code == tgt_code)   kind = REQ_SAME;
    else if (|src_hit)          kind = REQ_SRC;
    else if (tgt_code == OFF_CODE && test_mode) kind = REQ_OFF;
    else                        kind = REQ_BAD;
  end
endmodule

// File: rtl/sysclk_ready_mux.sv
module sysclk_ready_mux
  import sysclk_pkg::*;
(
  input  logic [NUM_SRC-1:0] chk_hit,
  input  logic [NUM_SRC-1:0] ready_vec,
  output logic               ready
);
  logic [NUM_SRC-1:0] gated;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    assign gated[g] = chk_hit[g] & ready_vec[g];
  end

  assign ready = |gated;
endmodule

// File: rtl/sysclk_sel_fsm.sv
module sysclk_sel_fsm
  import sysclk_pkg::*;
#(
  parameter int                CODE_W     = 4,
  parameter logic [CODE_W-1:0] RESET_CODE = 4'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  req_kind_e          kind,
  input  logic [NUM_SRC-1:0] src_hit,
  input  logic [CODE_W-1:0]  tgt_code,
  input  logic               ready,
  output logic [NUM_SRC-1:0] chk_hit,
  output logic [CODE_W-1:0]  sel,
  output logic               done,
  output logic               err,
  output logic               stable
);
  sel_state_e         state_q, state_d;
  logic [CODE_W-1:0]  sel_q, sel_d;
  logic [CODE_W-1:0]  pend_q;
  logic [NUM_SRC-1:0] pend_hit_q;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic               sel_en, pend_en;

  // While idle the incoming request is checked; while waiting the latched one
  assign chk_hit = (state_q == ST_IDLE) ? src_hit : pend_hit_q;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    sel_en  = 1'b0;
    pend_en = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          case (kind)
            REQ_SAME: done_d = 1'b1;
            REQ_BAD: begin
              done_d = 1'b1;
              err_d  = 1'b1;
            end
            REQ_OFF: begin
              sel_d  = tgt_code;
              sel_en = 1'b1;
              done_d = 1'b1;
            end
            default: begin
              if (ready) begin
                sel_d  = tgt_code;
                sel_en = 1'b1;
                done_d = 1'b1;
              end else begin
                pend_en = 1'b1;
                state_d = ST_WAIT;
              end
            end
          endcase
        end
      end
      default: begin
        if (ready) begin
          sel_d   = pend_q;
          sel_en  = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= RESET_CODE;
    else if (sel_en) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= RESET_CODE;
      pend_hit_q <= '0;
    end else if (pend_en) begin
      pend_q     <= tgt_code;
      pend_hit_q <= src_hit;
    end
  end

  assign sel    = sel_q;
  assign done   = done_q;
  assign err    = err_q;
  assign stable = (state_q == ST_IDLE);
endmodule

// File: rtl/sysclk_sel_ctrl.sv
module sysclk_sel_ctrl
  import sysclk_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] cur_code_i,
  input  logic [CODE_W-1:0] tgt_code_i,
  input  logic              test_mode_i,
  input  logic              rc_ready_i,
  input  logic              xtal_ready_i,
  input  logic              pll_ready_i,
  output logic [CODE_W-1:0] sel_o,
  output logic              done_o,
  output logic              err_o,
  output logic              stable_o
);
  localparam logic [CODE_W-1:0] CODE_RC   = CODE_W'(4'h0);
  localparam logic [CODE_W-1:0] CODE_XTAL = CODE_W'(4'h2);
  localparam logic [CODE_W-1:0] CODE_PLL  = CODE_W'(4'h4);
  localparam logic [CODE_W-1:0] CODE_OFF  = {CODE_W{1'b1}};
  localparam logic [NUM_SRC*CODE_W-1:0] SRC_CODES = {CODE_PLL, CODE_XTAL, CODE_RC};

  logic               rst_int_n;
  req_kind_e          kind;
  logic [NUM_SRC-1:0] src_hit;
  logic [NUM_SRC-1:0] chk_hit;
  logic [NUM_SRC-1:0] ready_vec;
  logic               ready;

  always_comb begin
    ready_vec           = '0;
    ready_vec[SRC_RC]   = rc_ready_i;
    ready_vec[SRC_XTAL] = xtal_ready_i;
    ready_vec[SRC_PLL]  = pll_ready_i;
  end

  sysclk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sysclk_req_decode #(
    .CODE_W    (CODE_W),
    .SRC_CODES (SRC_CODES),
    .OFF_CODE  (CODE_OFF)
  ) u_dec (
    .cur_code  (cur_code_i),
    .tgt_code  (tgt_code_i),
    .test_mode (test_mode_i),
    .kind      (kind),
    .src_hit   (src_hit)
  );

  sysclk_ready_mux u_mux (
    .chk_hit   (chk_hit),
    .ready_vec (ready_vec),
    .ready     (ready)
  );

  sysclk_sel_fsm #(
    .CODE_W     (CODE_W),
    .RESET_CODE (CODE_RC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start_i),
    .kind     (kind),
    .src_hit  (src_hit),
    .tgt_code (tgt_code_i),
    .ready    (ready),
    .chk_hit  (chk_hit),
    .sel      (sel_o),
    .done     (done_o),
    .err      (err_o),
    .stable   (stable_o)
  );
endmodule

// File: rtl/sysclk_sel_ctrl_chk.sv
module sysclk_sel_ctrl_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_mode_i,
  input logic              rc_ready_i,
  input logic              xtal_ready_i,
  input logic              pll_ready_i,
  input logic [CODE_W-1:0] sel_o,
  input logic              done_o,
  input logic              err_o,
  input logic              stable_o
);
  localparam logic [CODE_W-1:0] C_RC   = CODE_W'(4'h0);
  localparam logic [CODE_W-1:0] C_XTAL = CODE_W'(4'h2);
  localparam logic [CODE_W-1:0] C_PLL  = CODE_W'(4'h4);
  localparam logic [CODE_W-1:0] C_OFF  = {CODE_W{1'b1}};

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == C_RC || sel_o == C_XTAL || sel_o == C_PLL || sel_o == C_OFF)); // R8
  AST_RC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel_o) && sel_o == C_RC) |-> $past(rc_ready_i)); // R3
  AST_XTAL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel_o) && sel_o == C_XTAL) |-> $past(xtal_ready_i)); // R4
  AST_PLL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel_o) && sel_o == C_PLL) |-> $past(pll_ready_i)); // R5
  AST_OFF_TEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sel_o) && sel_o == C_OFF) |-> $past(test_mode_i)); // R7
  AST_SEL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_o) |-> done_o); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o); // R9
  AST_DONE_WHEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> stable_o); // R9
endmodule

bind sysclk_sel_ctrl sysclk_sel_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .test_mode_i  (test_mode_i),
  .rc_ready_i   (rc_ready_i),
  .xtal_ready_i (xtal_ready_i),
  .pll_ready_i  (pll_ready_i),
  .sel_o        (sel_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .stable_o     (stable_o)
);

// File: tb/sysclk_sel_ctrl_tb.sv
module sysclk_sel_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [3:0] cur_code_i, tgt_code_i;
  logic       test_mode_i;
  logic       rc_ready_i, xtal_ready_i, pll_ready_i;
  logic [3:0] sel_o;
  logic       done_o, err_o, stable_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_sel;

  always #10 clk = ~clk;

  sysclk_sel_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cur_code_i(cur_code_i), .tgt_code_i(tgt_code_i), .test_mode_i(test_mode_i),
    .rc_ready_i(rc_ready_i), .xtal_ready_i(xtal_ready_i), .pll_ready_i(pll_ready_i),
    .sel_o(sel_o), .done_o(done_o), .err_o(err_o), .stable_o(stable_o)
  );

  // 0 same, 1 source switch, 2 clock-off accepted, 3 refused
  function automatic int kind_of(logic [3:0] cur, logic [3:0] tgt, logic tm);
    if (cur == tgt) return 0;
    if (tgt == 4'h0 || tgt == 4'h2 || tgt == 4'h4) return 1;
    if (tgt == 4'hF && tm) return 2;
    return 3;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive the target's flag to val, the other flags at random
  task automatic set_ready(logic [3:0] tgt, logic val);
    rc_ready_i   = 1'($urandom);
    xtal_ready_i = 1'($urandom);
    pll_ready_i  = 1'($urandom);
    case (tgt)
      4'h0: rc_ready_i   = val;
      4'h2: xtal_ready_i = val;
      4'h4: pll_ready_i  = val;
      default: ;
    endcase
  endtask

  function automatic string req_of(logic [3:0] tgt);
    case (tgt)
      4'h0: return "R3";
      4'h2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic trial(logic [3:0] cur, logic [3:0] tgt, logic tm, int d, bit inject);
    int k;
    logic [3:0] old;
    k = kind_of(cur, tgt, tm);
    old = exp_sel;
    @(negedge clk);
    start_i = 1'b1; cur_code_i = cur; tgt_code_i = tgt; test_mode_i = tm;
    set_ready(tgt, (k == 1) && (d == 0));
    @(negedge clk);
    start_i = 1'b0;
    case (k)
      0: begin
        chk("R2 done", {3'b0, done_o}, 4'h1);
        chk("R2 err", {3'b0, err_o}, 4'h0);
        chk("R2 sel", sel_o, old);
      end
      2: begin
        chk("R6 done", {3'b0, done_o}, 4'h1);
        chk("R6 sel", sel_o, 4'hF);
        exp_sel = 4'hF;
      end
      3: begin
        chk((tgt == 4'hF) ? "R7 err" : "R8 err", {3'b0, err_o}, 4'h1);
        chk((tgt == 4'hF) ? "R7 done" : "R8 done", {3'b0, done_o}, 4'h1);
        chk((tgt == 4'hF) ? "R7 sel" : "R8 sel", sel_o, old);
      end
      default: begin
        if (d > 0) begin
          chk("R5 stable low while waiting", {3'b0, stable_o}, 4'h0);
          chk({req_of(tgt), " held"}, sel_o, old);
          for (int i = 1; i < d; i++) begin
            if (inject && i == 1) begin
              start_i = 1'b1;
              cur_code_i = tgt;
              tgt_code_i = (tgt == 4'h4) ? 4'h2 : 4'h4;
            end
            set_ready(tgt, 1'b0);
            @(negedge clk);
            start_i = 1'b0;
            chk(inject ? "R10 start ignored" : {req_of(tgt), " held"}, sel_o, old);
            chk("R9 no done while waiting", {3'b0, done_o}, 4'h0);
          end
          set_ready(tgt, 1'b1);
          @(negedge clk);
        end
        chk({req_of(tgt), " switched"}, sel_o, tgt);
        chk("R9 done on switch", {3'b0, done_o}, 4'h1);
        if (inject) chk("R10 pending target kept", sel_o, tgt);
        exp_sel = tgt;
      end
    endcase
    @(negedge clk);
    chk("R9 done one cycle", {3'b0, done_o}, 4'h0);
    chk("R9 err one cycle", {3'b0, err_o}, 4'h0);
    chk("R9 stable after", {3'b0, stable_o}, 4'h1);
    chk("R9 sel steady", sel_o, exp_sel);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start_i = 1'b0; cur_code_i = 4'h0; tgt_code_i = 4'h0;
    test_mode_i = 1'b0; rc_ready_i = 1'b0; xtal_ready_i = 1'b0; pll_ready_i = 1'b0;
    exp_sel = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sel", sel_o, 4'h0);
    chk("R1 stable", {3'b0, stable_o}, 4'h1);
    chk("R1 done", {3'b0, done_o}, 4'h0);
    chk("R1 err", {3'b0, err_o}, 4'h0);

    // Directed corner cases
    trial(4'h0, 4'h2, 1'b0, 0, 1'b0);  // R4 crystal already settled
    trial(4'h2, 4'h4, 1'b0, 4, 1'b1);  // R5 PLL lock delayed, R10 injected start
    trial(4'h4, 4'hF, 1'b0, 0, 1'b0);  // R7 clock off refused outside test
    trial(4'h4, 4'h7, 1'b1, 0, 1'b0);  // R8 invalid code
    trial(4'h4, 4'hF, 1'b1, 0, 1'b0);  // R6 clock off in test mode
    trial(4'hF, 4'h0, 1'b1, 3, 1'b0);  // R3 RC after clock off
    trial(4'h9, 4'h9, 1'b0, 0, 1'b0);  // R2 equal codes, even invalid
    trial(4'h0, 4'h4, 1'b0, 2, 1'b0);  // R5

    // Constrained random
    for (int n = 0; n < 300; n++) begin
      logic [3:0] c, t;
      int pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0, 1, 2: t = 4'h0 + 4'(2 * $urandom_range(0, 2));
        3:       t = 4'hF;
        4:       t = 4'($urandom);
        default: t = 4'(2 * $urandom_range(0, 2));
      endcase
      c = ($urandom_range(0, 5) == 0) ? t : 4'($urandom);
      trial(c, t, 1'($urandom), int'($urandom_range(0, 6)), ($urandom_range(0, 3) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule